// File: doc/BRIEF.md
# Reset First-Fetch Branch Injector

This block sits on the instruction-fetch path between a 32-bit processor core and on-chip RAM that is mapped at address zero. The core's reset vector is address 0x0000_0000, and that location holds RAM, so nothing non-volatile sits there. After any reset, the block answers the core's first fetch with a branch instruction that it builds itself. Every later fetch returns memory data unchanged. The address map is never remapped: only one instruction word is replaced, and it is replaced once.

The branch goes to one of two places: the on-chip boot ROM entry at 0x0000_4000, or the base of the external asynchronous memory window at 0x0200_0000. Two boot-select strap pins and a device-type pin choose between them. The pins are captured while reset is held. The external choice needs strap code 01 together with the general-purpose device type. Any other combination selects the ROM.

The control is a three-state machine:
- ST_ARMED waits for the first accepted fetch handshake.
- ST_WAIT_RSP waits for that fetch's response and replaces its data.
- ST_PASS forwards everything unchanged.

The transitions are:
- ARMED→WAIT_RSP when a fetch is accepted.
- WAIT_RSP→PASS on a response.
- Reset from any state back to ARMED.

Top module: `boot_branch_injector`

## Requirements
- R1: Reset is active while any of `por_n`, `warm_rst_n` or `max_rst_n` is low. During reset, and after release until the first override has been consumed, `override_done_o` is 0.
- R2: The strap pins and the device-type pin are sampled at every rising edge while reset is active. The value from the last such edge is held until the next reset, and pin changes after release have no effect on the branch target.
- R3: With `gp_device_i`=1 and `boot_sel_i`=2'b01, the branch target is 0x0200_0000.
- R4: With `boot_sel_i` = 2'b00, 2'b10 or 2'b11, or with `gp_device_i`=0 for any code, the branch target is 0x0000_4000.
- R5: The injected word has bits [31:24]=8'hEA and bits [23:0] equal to bits [25:2] of (target − (A + 8)). Here A is the address of the first accepted fetch, so a fetch at A=0 yields 32'hEA000FFE for the ROM target and 32'hEA7FFFFE for the external target.
- R6: The first fetch is the first cycle after reset with `core_fetch_valid_i` and `mem_fetch_ready_i` both 1, whatever its address. The next response (`mem_rsp_valid_i`=1), arriving one or more cycles later, is returned with the injected word in place of `mem_rsp_data_i`.
- R7: `override_done_o` rises the cycle after the replaced response and stays 1 until reset. From then on, `core_rsp_data_o` equals `mem_rsp_data_i` on every response.
- R8: The request path is a pass-through in the same cycle: `mem_fetch_valid_o`/`mem_fetch_addr_o` follow the core, and `core_fetch_ready_o` follows memory. `core_rsp_valid_o` follows `mem_rsp_valid_i`. A fetch offered while memory is not ready does not consume the override.
- R9: Without an accepted fetch, the override stays armed for any number of cycles. A response arriving before any accepted fetch passes through unchanged.
- R10: A reset asserted while the first fetch's response is still outstanding re-arms the override for the first fetch after release.
- R11: Each of the three reset inputs on its own re-arms the override and re-samples the straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| warm_rst_n | input | 1 | Warm reset, active low |
| max_rst_n | input | 1 | Max reset, active low |
| boot_sel_i | input | 2 | Boot-select strap pins |
| gp_device_i | input | 1 | 1 = general-purpose device variant |
| core_fetch_valid_i | input | 1 | Core fetch request valid |
| core_fetch_addr_i | input | 32 | Core fetch address |
| core_fetch_ready_o | output | 1 | Fetch accepted (from memory) |
| mem_fetch_valid_o | output | 1 | Fetch request to memory |
| mem_fetch_addr_o | output | 32 | Fetch address to memory |
| mem_fetch_ready_i | input | 1 | Memory accepts fetch |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_data_i | input | 32 | Memory response instruction word |
| core_rsp_valid_o | output | 1 | Response valid to core |
| core_rsp_data_o | output | 32 | Instruction word to core |
| override_done_o | output | 1 | Injected branch has been delivered |

## Verification
The bench walks all four strap codes with both device types. This catches a design that honours code 01 on a non-general-purpose part, or that decodes 10 or 11 as external. It changes the strap pins right after reset release and checks that a latch which kept tracking the pins would send the branch elsewhere. It holds a fetch while memory is not ready, sends a stray response before any fetch, and fetches from a non-zero address. A design that counts an offered request as accepted, triggers on any response, or hard-codes the offset for address zero would each return the wrong word. Finally, it asserts each reset type separately, including one with a fetch outstanding, and checks that the next first fetch is overridden again rather than passed through.

// File: rtl/boot_inj_pkg.sv
package boot_inj_pkg;

    localparam int WORD_W = 32;

    // Branch encoding: always-condition plus branch opcode in the top byte
    localparam logic [3:0] COND_ALWAYS = 4'hE;
    localparam logic [3:0] OP_BRANCH   = 4'hA;
    localparam int         OFFSET_W    = 24;
    localparam int         PC_AHEAD    = 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_ARMED    = 2'd0,
        ST_WAIT_RSP = 2'd1,
        ST_PASS     = 2'd2
    } inj_state_e;

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch #(
    parameter int               SEL_W    = 2,
    parameter logic [SEL_W-1:0] EXT_CODE = 2'b01
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             gp_i,
    output logic             ext_o
);

    logic ext_q;

    // Tracks the pins during reset; frozen once reset is released
    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= gp_i && (sel_i == EXT_CODE);
        end
    end

    assign ext_o = ext_q;

endmodule

// File: rtl/boot_branch_encoder.sv
module boot_branch_encoder
    import boot_inj_pkg::*;
(
    input  word_t target_i,
    input  word_t fetch_addr_i,
    output word_t word_o
);

    word_t pc_view;
    word_t byte_delta;

    always_comb begin
        pc_view    = fetch_addr_i + word_t'(PC_AHEAD);
        byte_delta = target_i - pc_view;
        word_o     = {COND_ALWAYS, OP_BRANCH, byte_delta[OFFSET_W+1:2]};
    end

endmodule

// File: rtl/boot_fetch_fsm.sv
module boot_fetch_fsm
    import boot_inj_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fetch_fire_i,
    input  logic  rsp_valid_i,
    input  word_t fetch_addr_i,
    output logic  inject_o,
    output logic  done_o,
    output word_t first_addr_o
);

    inj_state_e state_q;
    inj_state_e state_d;
    word_t      first_addr_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Address of the first accepted fetch
    always_ff @(posedge clk) begin
        if (rst) begin
            first_addr_q <= '0;
        end else if (state_q == ST_ARMED && fetch_fire_i) begin
            first_addr_q <= fetch_addr_i;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:    if (fetch_fire_i) state_d = ST_WAIT_RSP;
            ST_WAIT_RSP: if (rsp_valid_i)  state_d = ST_PASS;
            ST_PASS:     state_d = ST_PASS;
            default:     state_d = ST_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        inject_o = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_ARMED:    ;
            ST_WAIT_RSP: inject_o = rsp_valid_i;
            ST_PASS:     done_o   = 1'b1;
            default:     ;
        endcase
    end

    assign first_addr_o = first_addr_q;

endmodule

// File: rtl/boot_branch_injector.sv
module boot_branch_injector
    import boot_inj_pkg::*;
#(
    parameter int               SEL_W     = 2,
    parameter logic [SEL_W-1:0] EXT_CODE  = 2'b01,
    parameter word_t            ROM_ENTRY = 32'h0000_4000,
    parameter word_t            EXT_BASE  = 32'h0200_0000
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_rst_n,
    input  logic             max_rst_n,
    input  logic [SEL_W-1:0] boot_sel_i,
    input  logic             gp_device_i,
    input  logic             core_fetch_valid_i,
    input  logic [31:0]      core_fetch_addr_i,
    output logic             core_fetch_ready_o,
    output logic             mem_fetch_valid_o,
    output logic [31:0]      mem_fetch_addr_o,
    input  logic             mem_fetch_ready_i,
    input  logic             mem_rsp_valid_i,
    input  logic [31:0]      mem_rsp_data_i,
    output logic             core_rsp_valid_o,
    output logic [31:0]      core_rsp_data_o,
    output logic             override_done_o
);

    logic  rst_any;
    logic  ext_boot_q;
    logic  fetch_fire;
    logic  inject;
    word_t first_addr;
    word_t target;
    word_t branch_word;

    assign rst_any    = !(por_n && warm_rst_n && max_rst_n);
    assign fetch_fire = core_fetch_valid_i && mem_fetch_ready_i;

    boot_strap_latch #(
        .SEL_W    (SEL_W),
        .EXT_CODE (EXT_CODE)
    ) u_strap (
        .clk   (clk),
        .rst   (rst_any),
        .sel_i (boot_sel_i),
        .gp_i  (gp_device_i),
        .ext_o (ext_boot_q)
    );

    boot_fetch_fsm u_fsm (
        .clk          (clk),
        .rst          (rst_any),
        .fetch_fire_i (fetch_fire),
        .rsp_valid_i  (mem_rsp_valid_i),
        .fetch_addr_i (core_fetch_addr_i),
        .inject_o     (inject),
        .done_o       (override_done_o),
        .first_addr_o (first_addr)
    );

    assign target = ext_boot_q ? EXT_BASE : ROM_ENTRY;

    boot_branch_encoder u_enc (
        .target_i     (target),
        .fetch_addr_i (first_addr),
        .word_o       (branch_word)
    );

    // Request side: straight through
    assign mem_fetch_valid_o  = core_fetch_valid_i;
    assign mem_fetch_addr_o   = core_fetch_addr_i;
    assign core_fetch_ready_o = mem_fetch_ready_i;

    // Response side: one-time substitution
    assign core_rsp_valid_o = mem_rsp_valid_i;
    assign core_rsp_data_o  = inject ? branch_word : mem_rsp_data_i;

endmodule

// File: rtl/boot_inj_checker.sv
module boot_inj_checker (
    input logic        clk,
    input logic        rst,
    input logic        ext_sel,
    input logic        mem_rsp_valid_i,
    input logic [31:0] mem_rsp_data_i,
    input logic        core_rsp_valid_o,
    input logic [31:0] core_rsp_data_o,
    input logic        override_done_o
);

    AST_RESET_CLEARS_DONE: assert property (@(posedge clk) rst |=> !override_done_o); // R1

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(ext_sel)); // R2

    AST_OPCODE_BYTE: assert property (@(posedge clk) disable iff (rst)
        (!override_done_o && core_rsp_valid_o && core_rsp_data_o != mem_rsp_data_i)
        |-> core_rsp_data_o[31:24] == 8'hEA); // R5

    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        $rose(override_done_o) |-> $past(mem_rsp_valid_i)); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        override_done_o |=> override_done_o); // R7

    AST_PASS_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (override_done_o && mem_rsp_valid_i) |-> core_rsp_data_o == mem_rsp_data_i); // R7

endmodule

bind boot_branch_injector boot_inj_checker u_chk (
    .clk              (clk),
    .rst              (rst_any),
    .ext_sel          (ext_boot_q),
    .mem_rsp_valid_i  (mem_rsp_valid_i),
    .mem_rsp_data_i   (mem_rsp_data_i),
    .core_rsp_valid_o (core_rsp_valid_o),
    .core_rsp_data_o  (core_rsp_data_o),
    .override_done_o  (override_done_o)
);

// File: tb/tb_boot_branch_injector.sv
`timescale 1ns/1ps
module tb_boot_branch_injector;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, warm_rst_n = 1'b1, max_rst_n = 1'b1;
    logic [1:0]  boot_sel = 2'b00;
    logic        gp_dev = 1'b1;
    logic        core_valid = 1'b0;
    logic [31:0] core_addr = '0;
    logic        core_ready, mem_valid;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b0, rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        core_rsp_valid;
    logic [31:0] core_rsp_data;
    logic        done;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    boot_branch_injector dut (
        .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .max_rst_n(max_rst_n),
        .boot_sel_i(boot_sel), .gp_device_i(gp_dev),
        .core_fetch_valid_i(core_valid), .core_fetch_addr_i(core_addr),
        .core_fetch_ready_o(core_ready), .mem_fetch_valid_o(mem_valid),
        .mem_fetch_addr_o(mem_addr), .mem_fetch_ready_i(mem_ready),
        .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
        .core_rsp_valid_o(core_rsp_valid), .core_rsp_data_o(core_rsp_data),
        .override_done_o(done)
    );

    localparam logic [31:0] ROM_T = 32'h0000_4000;
    localparam logic [31:0] EXT_T = 32'h0200_0000;

    // {gp, sel[1:0], expected target}
    localparam logic [34:0] VEC [8] = '{
        {1'b1, 2'b00, ROM_T}, {1'b1, 2'b01, EXT_T},
        {1'b1, 2'b10, ROM_T}, {1'b1, 2'b11, ROM_T},
        {1'b0, 2'b00, ROM_T}, {1'b0, 2'b01, ROM_T},
        {1'b0, 2'b10, ROM_T}, {1'b0, 2'b11, ROM_T}
    };

    function automatic logic [31:0] exp_branch(logic [31:0] tgt, logic [31:0] a);
        logic [31:0] d;
        d = tgt - a - 32'd8;
        return {8'hEA, d[25:2]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // kind: 0 power-on, 1 warm, 2 max
    task automatic do_reset(input int kind, input logic gp, input logic [1:0] sel);
        @(negedge clk);
        gp_dev = gp; boot_sel = sel;
        core_valid = 0; mem_ready = 0; rsp_valid = 0;
        case (kind)
            0: por_n = 0;
            1: warm_rst_n = 0;
            default: max_rst_n = 0;
        endcase
        repeat (2) @(negedge clk);
        check(done == 1'b0, "R1", "done during reset", 32'(done), 32'd0);
        por_n = 1; warm_rst_n = 1; max_rst_n = 1;
        @(negedge clk);
        check(done == 1'b0, "R1", "done after release", 32'(done), 32'd0);
        gp_dev = ~gp; boot_sel = ~sel;  // late pin changes must be ignored (R2)
    endtask

    task automatic fetch(input logic [31:0] a, input logic [31:0] md, output logic [31:0] got);
        @(negedge clk);
        core_valid = 1; core_addr = a; mem_ready = 1;
        @(negedge clk);
        core_valid = 0; mem_ready = 0; rsp_valid = 1; rsp_data = md;
        #1 got = core_rsp_data;
        @(negedge clk);
        rsp_valid = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] got;
        repeat (3) @(negedge clk);
        por_n = 1;
        @(negedge clk);
        check(done == 1'b0, "R1", "reset state done", 32'(done), 32'd0);

        // Table walk: all strap codes and both device types
        for (int i = 0; i < 8; i++) begin
            logic [31:0] tgt;
            tgt = VEC[i][31:0];
            do_reset(i % 3, VEC[i][34], VEC[i][33:32]);
            fetch(32'h0, 32'h1111_0000 + i, got);
            check(got == exp_branch(tgt, 32'h0),
                  (tgt == EXT_T) ? "R3/R5 R2" : "R4/R5 R2", "first word", got, exp_branch(tgt, 32'h0));
            check(done == 1'b1, "R7", "done after first", 32'(done), 32'd1);
            fetch(32'h4, 32'hA5A5_0000 + i, got);
            check(got == 32'hA5A5_0000 + i, "R7", "second fetch pass", got, 32'hA5A5_0000 + i);
            fetch(32'h8, 32'h5A5A_0000 + i, got);
            check(got == 32'h5A5A_0000 + i, "R7", "third fetch pass", got, 32'h5A5A_0000 + i);
        end

        // Known opcodes at address zero
        check(exp_branch(ROM_T, 0) == 32'hEA000FFE, "R5", "rom opcode", exp_branch(ROM_T, 0), 32'hEA000FFE);
        check(exp_branch(EXT_T, 0) == 32'hEA7FFFFE, "R5", "ext opcode", exp_branch(EXT_T, 0), 32'hEA7FFFFE);

        // R9: long idle, then a stray response, then the real first fetch
        do_reset(0, 1'b1, 2'b01);
        repeat (40) @(negedge clk);
        check(done == 1'b0, "R9", "still armed", 32'(done), 32'd0);
        rsp_valid = 1; rsp_data = 32'hDEAD_BEEF;
        #1 check(core_rsp_data == 32'hDEAD_BEEF, "R9", "stray rsp pass", core_rsp_data, 32'hDEAD_BEEF);
        @(negedge clk); rsp_valid = 0;

        // R8: offered but not accepted fetch does not consume override
        core_valid = 1; core_addr = 32'h0000_0040; mem_ready = 0;
        #1;
        check(mem_valid == 1'b1 && mem_addr == 32'h40, "R8", "req pass", mem_addr, 32'h40);
        check(core_ready == 1'b0, "R8", "ready pass", 32'(core_ready), 32'd0);
        repeat (3) @(negedge clk);
        core_valid = 0;
        check(done == 1'b0, "R8", "no handshake no consume", 32'(done), 32'd0);
        fetch(32'h0, 32'h1234_5678, got);
        check(got == 32'hEA7FFFFE, "R6", "first accepted fetch ext", got, 32'hEA7FFFFE);

        // R5/R6: first fetch at a non-zero address
        do_reset(1, 1'b1, 2'b11);
        fetch(32'h0000_0100, 32'h0BAD_0000, got);
        check(got == exp_branch(ROM_T, 32'h100), "R5", "nonzero addr", got, exp_branch(ROM_T, 32'h100));

        // R10: reset while the first response is outstanding
        do_reset(0, 1'b1, 2'b00);
        @(negedge clk);
        core_valid = 1; core_addr = 0; mem_ready = 1;
        @(negedge clk);
        core_valid = 0; mem_ready = 0;
        max_rst_n = 0; gp_dev = 1; boot_sel = 2'b01;
        repeat (2) @(negedge clk);
        max_rst_n = 1;
        @(negedge clk);
        check(done == 1'b0, "R10", "rearmed", 32'(done), 32'd0);
        fetch(32'h0, 32'h7777_7777, got);
        check(got == 32'hEA7FFFFE, "R10", "override after mid reset", got, 32'hEA7FFFFE);

        // R11: each reset type re-arms after the override was consumed
        for (int k = 0; k < 3; k++) begin
            do_reset(k, 1'b1, 2'b01);
            fetch(32'h0, 32'h3333_0000 + k, got);
            check(got == 32'hEA7FFFFE, "R11", "rearm per reset type", got, 32'hEA7FFFFE);
            fetch(32'h4, 32'h4444_0000 + k, got);
            check(got == 32'h4444_0000 + k, "R11", "pass after rearm", got, 32'h4444_0000 + k);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule